// File: doc/BRIEF.md
# Byte-Lane Strobe Generator with Endian-Mode Switch

This block decides, for each CPU transfer, which active-low byte strobes go out. It drives eight memory column strobes for DRAM accesses and four PCI byte enables for transfers aimed at PCI. It works from the transfer's size code, the three low address bits, the direction and the current endian mode. In little-endian mode the CPU presents a munged low address. The block first restores the true byte address by XOR with a size-dependent mask, and then selects lanes from that restored address. The strobe outputs are combinational, so they are valid in the same cycle as the transfer inputs.

The block also holds the endian-mode select that feeds the data path. A request input is captured into a staging flop on every clock edge. The select takes the staged value only on an edge at which both the CPU bus and the PCI bus report idle, so the mode never flips during a bus transaction. A transfer that cannot be carried out raises an illegal flag and asserts no strobes. This covers an unknown size code, a misaligned address, or an eight-byte transfer to PCI.

Top module: `lbs_strobe_gen`

## Requirements
- R1: Size codes are 3'b000 = 8 bytes, 3'b001 = 1 byte, 3'b010 = 2 bytes and 3'b100 = 4 bytes. Any other code, or an address that is not a multiple of the byte count, makes `illegal_o` high while `xfer_valid_i` is high, and all strobes stay high.
- R2: When `le_sel_o` is 1 (little-endian), the lane address is `xfer_addr_i` XOR 3'b111, 3'b110, 3'b100 or 3'b000 for 1, 2, 4 or 8 bytes. When `le_sel_o` is 0 (big-endian), the address is used unchanged.
- R3: A valid, legal memory read (`xfer_we_i`=0, `xfer_pci_i`=0) drives all eight bits of `col_n_o` low, whatever the size.
- R4: A valid, legal memory write drives `col_n_o[k]` low exactly for k from the lane address up to lane address + bytes - 1.
- R5: A valid, legal PCI transfer (read or write) drives `be_n_o[k]` low exactly for k from the lane address bits [1:0] up to those bits + bytes - 1, and keeps `col_n_o` all high.
- R6: An 8-byte transfer with `xfer_pci_i`=1 raises `illegal_o` and asserts no byte enable.
- R7: A memory transfer keeps `be_n_o` all high. With `xfer_valid_i` low, every strobe is high and `illegal_o` is low.
- R8: `mode_req_i` is registered on every clock edge. On each edge where `cpu_idle_i` and `pci_idle_i` are both high, `le_sel_o` loads the previously registered request; on all other edges it holds.
- R9: While `rst_ni` is low, `le_sel_o` is 0 (big-endian) and the staged request is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| xfer_valid_i | input | 1 | A transfer is presented this cycle |
| xfer_we_i | input | 1 | 1 = write, 0 = read |
| xfer_pci_i | input | 1 | 1 = PCI target, 0 = system memory |
| xfer_size_i | input | 3 | Size code (see R1) |
| xfer_addr_i | input | 3 | Low address bits as driven by the CPU |
| mode_req_i | input | 1 | Little-endian request, 1 = little |
| cpu_idle_i | input | 1 | CPU bus is idle |
| pci_idle_i | input | 1 | PCI bus is idle |
| col_n_o | output | 8 | Memory column strobes, active low, bit k = byte k |
| be_n_o | output | 4 | PCI byte enables, active low |
| illegal_o | output | 1 | The presented transfer cannot be carried out |
| le_sel_o | output | 1 | Endian select to the data path, 1 = little |

## Verification
The assertions assume that the idle inputs are honest. A transfer and an idle indication may coincide on the pins, and the block does not police this; the checks only require that the select moves on an edge where both idles were high. They also assume the inputs are stable between clock edges. The stimulus is applied on falling edges and drawn from a fixed seed. It covers every size code, including undefined ones, every address, both targets and both directions. It mixes random idle and request patterns so that mode changes land in the middle of the transfer stream.

// File: rtl/lbs_pkg.sv
package lbs_pkg;
  typedef enum logic {
    ENDIAN_BIG    = 1'b0,
    ENDIAN_LITTLE = 1'b1
  } endian_e;

  localparam int unsigned MEM_LANES_DEF = 8;
  localparam int unsigned PCI_LANES_DEF = 4;
endpackage

// File: rtl/lbs_unmunge.sv
module lbs_unmunge #(
  parameter int unsigned AW = 3
) (
  input  logic          le_i,
  input  logic [AW-1:0] size_i,
  input  logic [AW-1:0] addr_i,
  output logic [AW-1:0] ua_o,
  output logic [AW:0]   nbytes_o,
  output logic          legal_o
);
  logic [AW-1:0] span;
  logic          size_ok;
  logic          aligned;

  always_comb begin
    size_ok  = (size_i == '0) || $onehot(size_i);
    // size code 0 means full lane width
    span     = (size_i == '0) ? '1 : size_i - AW'(1);
    nbytes_o = (size_i == '0) ? (AW+1)'(1 << AW) : {1'b0, size_i};
    aligned  = (addr_i & span) == '0;
    legal_o  = size_ok && aligned;
    ua_o     = le_i ? (addr_i ^ ~span) : addr_i;
  end
endmodule

// File: rtl/lbs_lane_decode.sv
module lbs_lane_decode #(
  parameter int unsigned N  = 8,
  parameter int unsigned BW = (N > 1) ? $clog2(N) : 1,
  parameter int unsigned CW = BW + 2
) (
  input  logic [BW-1:0] base_i,
  input  logic [CW-1:0] cnt_i,
  output logic [N-1:0]  hit_o
);
  for (genvar k = 0; k < N; k++) begin : g_lane
    localparam int K = k;
    assign hit_o[k] = (K >= int'(base_i)) && (K < int'(base_i) + int'(cnt_i));
  end
endmodule

// File: rtl/lbs_mode_reg.sv
module lbs_mode_reg (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic req_i,
  input  logic cpu_idle_i,
  input  logic pci_idle_i,
  output logic le_o
);
  import lbs_pkg::*;

  logic    req_q;
  endian_e sel_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_q <= 1'b0;
      sel_q <= ENDIAN_BIG;
    end else begin
      req_q <= req_i;
      if (cpu_idle_i && pci_idle_i)
        sel_q <= endian_e'(req_q);
    end
  end

  assign le_o = (sel_q == ENDIAN_LITTLE);
endmodule

// File: rtl/lbs_strobe_gen.sv
module lbs_strobe_gen #(
  parameter int unsigned LANES     = lbs_pkg::MEM_LANES_DEF,
  parameter int unsigned PCI_LANES = lbs_pkg::PCI_LANES_DEF
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         xfer_valid_i,
  input  logic                         xfer_we_i,
  input  logic                         xfer_pci_i,
  input  logic [$clog2(LANES)-1:0]     xfer_size_i,
  input  logic [$clog2(LANES)-1:0]     xfer_addr_i,
  input  logic                         mode_req_i,
  input  logic                         cpu_idle_i,
  input  logic                         pci_idle_i,
  output logic [LANES-1:0]             col_n_o,
  output logic [PCI_LANES-1:0]         be_n_o,
  output logic                         illegal_o,
  output logic                         le_sel_o
);
  localparam int unsigned AW  = $clog2(LANES);
  localparam int unsigned PAW = $clog2(PCI_LANES);

  logic [AW-1:0]        ua;
  logic [AW:0]          nbytes;
  logic                 legal;
  logic [LANES-1:0]     mem_hit;
  logic [PCI_LANES-1:0] pci_hit;
  logic                 pci_fit;
  logic                 ok;
  logic [LANES-1:0]     col_act;
  logic [PCI_LANES-1:0] be_act;

  lbs_mode_reg u_mode (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .req_i      (mode_req_i),
    .cpu_idle_i (cpu_idle_i),
    .pci_idle_i (pci_idle_i),
    .le_o       (le_sel_o)
  );

  lbs_unmunge #(.AW(AW)) u_unmunge (
    .le_i     (le_sel_o),
    .size_i   (xfer_size_i),
    .addr_i   (xfer_addr_i),
    .ua_o     (ua),
    .nbytes_o (nbytes),
    .legal_o  (legal)
  );

  lbs_lane_decode #(.N(LANES), .BW(AW), .CW(AW+1)) u_mem_dec (
    .base_i (ua),
    .cnt_i  (nbytes),
    .hit_o  (mem_hit)
  );

  lbs_lane_decode #(.N(PCI_LANES), .BW(PAW), .CW(AW+1)) u_pci_dec (
    .base_i (ua[PAW-1:0]),
    .cnt_i  (nbytes),
    .hit_o  (pci_hit)
  );

  always_comb begin
    pci_fit   = int'(nbytes) <= int'(PCI_LANES);
    ok        = xfer_valid_i && legal && (!xfer_pci_i || pci_fit);
    illegal_o = xfer_valid_i && !ok;
    col_act   = '0;
    be_act    = '0;
    if (ok) begin
      if (xfer_pci_i) be_act  = pci_hit;
      else            col_act = xfer_we_i ? mem_hit : '1;  // reads fetch the whole row
    end
    col_n_o = ~col_act;
    be_n_o  = ~be_act;
  end
endmodule

// File: rtl/lbs_strobe_gen_chk.sv
module lbs_strobe_gen_chk #(
  parameter int unsigned LANES     = 8,
  parameter int unsigned PCI_LANES = 4
) (
  input logic                     clk_i,
  input logic                     rst_ni,
  input logic                     xfer_valid_i,
  input logic                     xfer_we_i,
  input logic                     xfer_pci_i,
  input logic [$clog2(LANES)-1:0] xfer_size_i,
  input logic [$clog2(LANES)-1:0] xfer_addr_i,
  input logic                     mode_req_i,
  input logic                     cpu_idle_i,
  input logic                     pci_idle_i,
  input logic [LANES-1:0]         col_n_o,
  input logic [PCI_LANES-1:0]     be_n_o,
  input logic                     illegal_o,
  input logic                     le_sel_o
);
  // R3
  mem_read_all_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (xfer_valid_i && !xfer_we_i && !xfer_pci_i && !illegal_o) |-> (col_n_o == '0));

  // R7
  target_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (col_n_o != '1) |-> (be_n_o == '1));

  // R1
  illegal_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    illegal_o |-> ((col_n_o == '1) && (be_n_o == '1)));

  // R6
  pci_dword_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (xfer_valid_i && xfer_pci_i && (xfer_size_i == '0)) |-> illegal_o);

  // R8
  mode_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(le_sel_o) |-> $past(cpu_idle_i && pci_idle_i));

  // R4
  byte_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (xfer_valid_i && xfer_we_i && !xfer_pci_i && (xfer_size_i == 1) && !illegal_o)
      |-> ($countones(~col_n_o) == 1));

  // R5
  pci_count_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (xfer_valid_i && xfer_pci_i && !illegal_o)
      |-> ($countones(~be_n_o) == int'(xfer_size_i)));
endmodule

bind lbs_strobe_gen lbs_strobe_gen_chk #(.LANES(LANES), .PCI_LANES(PCI_LANES)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .xfer_valid_i (xfer_valid_i),
  .xfer_we_i    (xfer_we_i),
  .xfer_pci_i   (xfer_pci_i),
  .xfer_size_i  (xfer_size_i),
  .xfer_addr_i  (xfer_addr_i),
  .mode_req_i   (mode_req_i),
  .cpu_idle_i   (cpu_idle_i),
  .pci_idle_i   (pci_idle_i),
  .col_n_o      (col_n_o),
  .be_n_o       (be_n_o),
  .illegal_o    (illegal_o),
  .le_sel_o     (le_sel_o)
);

// File: tb/lbs_strobe_gen_bench.sv
module lbs_strobe_gen_bench;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       valid = 1'b0, we = 1'b0, pci = 1'b0;
  logic [2:0] size = 3'd0, addr = 3'd0;
  logic       mreq = 1'b0, cidle = 1'b0, pidle = 1'b0;
  logic [7:0] col_n;
  logic [3:0] be_n;
  logic       ill, le;

  int total = 0, bad = 0;
  bit done = 1'b0;
  logic m_req, m_le;

  always #(CLK_PERIOD/2) clk = ~clk;

  lbs_strobe_gen u_lbs_strobe_gen (
    .clk_i(clk), .rst_ni(rst_n), .xfer_valid_i(valid), .xfer_we_i(we),
    .xfer_pci_i(pci), .xfer_size_i(size), .xfer_addr_i(addr),
    .mode_req_i(mreq), .cpu_idle_i(cidle), .pci_idle_i(pidle),
    .col_n_o(col_n), .be_n_o(be_n), .illegal_o(ill), .le_sel_o(le)
  );

  // R8/R9 mode model
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_req <= 1'b0;
      m_le  <= 1'b0;
    end else begin
      m_req <= mreq;
      if (cidle && pidle) m_le <= m_req;
    end
  end

  task automatic expect_out(input logic lem, output logic [7:0] ec,
                            output logic [3:0] eb, output logic ei);
    int n, mask, ua;
    case (size)
      3'd1: begin n = 1; mask = 7; end
      3'd2: begin n = 2; mask = 6; end
      3'd4: begin n = 4; mask = 4; end
      3'd0: begin n = 8; mask = 0; end
      default: begin n = 0; mask = 0; end
    endcase
    ua = lem ? (int'(addr) ^ mask) : int'(addr);
    ei = valid && (n == 0 || (int'(addr) % n) != 0 || (pci && n == 8));
    ec = 8'hff;
    eb = 4'hf;
    if (valid && !ei) begin
      if (pci) for (int i = 0; i < n; i++) eb[(ua % 4) + i] = 1'b0;
      else if (!we) ec = 8'h00;
      else for (int i = 0; i < n; i++) ec[ua + i] = 1'b0;
    end
  endtask

  task automatic check(input string tag);
    logic [7:0] ec; logic [3:0] eb; logic ei;
    expect_out(m_le, ec, eb, ei);
    total++;
    if (col_n !== ec || be_n !== eb || ill !== ei || le !== m_le) begin
      bad++;
      $display("FAIL %s: col=%b be=%b ill=%b le=%b exp col=%b be=%b ill=%b le=%b",
               tag, col_n, be_n, ill, le, ec, eb, ei, m_le);
    end
  endtask

  task automatic xfer(input logic v, input logic w, input logic p,
                      input logic [2:0] s, input logic [2:0] a, input string tag);
    @(negedge clk);
    valid = v; we = w; pci = p; size = s; addr = a;
    #2 check(tag);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    total++; bad++;
    $display("FAIL watchdog: run hung, actual=timeout expected=finish");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    #2 check("R9 reset");
    @(negedge clk); rst_n = 1'b1;
    // big-endian directed
    xfer(1, 1, 0, 3'd1, 3'b010, "R4 byte write 010");
    xfer(1, 1, 0, 3'd2, 3'b010, "R4 half write 010");
    xfer(1, 1, 0, 3'd4, 3'b100, "R4 word write 100");
    xfer(1, 1, 0, 3'd0, 3'b000, "R4 dword write");
    xfer(1, 0, 0, 3'd1, 3'b011, "R3 byte read");
    xfer(1, 1, 1, 3'd1, 3'b010, "R5 pci byte 010");
    xfer(1, 0, 1, 3'd4, 3'b100, "R5 pci word read");
    xfer(1, 1, 1, 3'd0, 3'b000, "R6 pci dword");
    xfer(1, 1, 0, 3'd2, 3'b001, "R1 misaligned half");
    xfer(1, 1, 0, 3'd3, 3'b000, "R1 bad size code");
    xfer(0, 1, 0, 3'd1, 3'b000, "R7 idle");
    // mode switch deferred while busy
    @(negedge clk); valid = 0; mreq = 1; cidle = 0; pidle = 1;
    repeat (3) @(negedge clk);
    #2 check("R8 held while cpu busy");
    @(negedge clk); cidle = 1; pidle = 0;
    @(negedge clk); #2 check("R8 held while pci busy");
    @(negedge clk); pidle = 1;
    @(negedge clk); #2 check("R8 switch when idle");
    if (le !== 1'b1) begin
      total++; bad++;
      $display("FAIL R8 switch: le=%b expected=1", le);
    end
    @(negedge clk); cidle = 0; pidle = 0;
    // little-endian directed
    xfer(1, 1, 0, 3'd1, 3'b101, "R2 le byte 101");
    xfer(1, 1, 0, 3'd2, 3'b100, "R2 le half 100");
    xfer(1, 1, 0, 3'd4, 3'b000, "R2 le word 000");
    xfer(1, 1, 1, 3'd4, 3'b000, "R2 le pci word");
    xfer(1, 1, 0, 3'd0, 3'b000, "R2 le dword");
    xfer(1, 0, 0, 3'd2, 3'b110, "R3 le half read");
    // random mix
    void'($urandom(32'h1bad5eed));
    for (int i = 0; i < 600; i++) begin
      @(negedge clk);
      valid = ($urandom % 8) != 0;
      we    = $urandom % 2;
      pci   = $urandom % 2;
      case ($urandom % 6)
        0: size = 3'd1; 1: size = 3'd2; 2: size = 3'd4;
        3: size = 3'd0; 4: size = 3'd1; default: size = 3'($urandom);
      endcase
      addr  = 3'($urandom);
      if (($urandom % 16) == 0) mreq = ~mreq;
      cidle = ($urandom % 3) == 0;
      pidle = ($urandom % 3) != 0;
      #2 check("R1-mix random");
    end
    finish_run();
  end
endmodule